// File: doc/BRIEF.md
# Two-Partition Shared Stream Router

When a streaming state machine is split across two pages, both halves may need the same input stream and the same output stream, and only one half holds control at any moment. This block sits between the shared streams and the two halves. Each half is modelled only as a token sink (delivery port), a token source (result port) and the handoff events that pass control between them. The router records the owner from those events, so token order across the pages follows the control flow and no central arbiter is needed.

Input tokens are routed by one of three schemes, chosen by two static configuration pins: broadcast, directed request-on-read, or directed prefetch. In broadcast, the copy meant for the partition that does not own control is absorbed by that partition's discard counter. The counter is loaded at handoff with the number of tokens the new owner will consume. The result streams are merged into one output by taking tokens only from the owner.

All streams use valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. A source must keep valid and data steady until its token is taken. The router never holds a token back from a sink once valid is shown, except as the rules below allow. Back-pressure on the output stream passes straight to the owner's source, and back-pressure from the owner's delivery port passes straight to the input stream.

Top module: `shared_stream_router`

## Requirements
- R1: After reset no partition owns control. While no partition owns control, in_ready, both dlv_valid bits, out_valid and both src_ready bits are 0.
- R2: A handoff (hand_vld=1) naming partition X makes X the owner from the next cycle. A handoff that names the current owner is ignored: ownership and the discard counts stay unchanged.
- R3: The output stream carries the owner's source: out_valid=src_valid[owner] and out_data=src_data[owner]. src_ready[owner]=out_ready, and the non-owner's src_ready bit is 0.
- R4: In broadcast mode (cfg_directed=0), an input token is offered on the owner's delivery port with dlv_data equal to in_data. It is accepted only when that port is ready and the non-owner's discard count is nonzero. Each accepted token decrements that count by one.
- R5: A non-self handoff to partition X loads the discard count of the other partition with hand_cnt. In broadcast mode, while the non-owner's count is zero, in_ready is 0 and the owner is offered nothing.
- R6: In directed request mode (cfg_directed=1, cfg_prefetch=0), the input passes combinationally to the owner's delivery port, and in_ready equals the owner's dlv_ready.
- R7: In directed prefetch mode (cfg_directed=1, cfg_prefetch=1), each partition has a one-token slot. Only the owner's slot is filled. in_ready=1 when the owner's slot is empty or is being emptied in the same cycle. A stored token is offered one cycle after acceptance at the earliest.
- R8: In prefetch mode, a token held in a partition's slot stays there unchanged while that partition does not own control. It is delivered only after that partition becomes the owner again.
- R9: At most one dlv_valid bit is high, and only the owner's bit can be. Every accepted input token reaches exactly one partition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_directed | input | 1 | 0 = broadcast, 1 = directed (static) |
| cfg_prefetch | input | 1 | In directed mode: 0 = request-on-read, 1 = prefetch (static) |
| hand_vld | input | 1 | Handoff event strobe |
| hand_to | input | 1 | Partition that receives control |
| hand_cnt | input | CW | Tokens the new owner will consume (broadcast discard load) |
| in_valid | input | 1 | Shared input stream valid |
| in_ready | output | 1 | Shared input stream ready |
| in_data | input | W | Shared input stream data |
| dlv_valid | output | 2 | Per-partition delivery valid |
| dlv_ready | input | 2 | Per-partition delivery ready |
| dlv_data | output | 2*W | Per-partition delivery data, partition i at bits i*W +: W |
| src_valid | input | 2 | Per-partition result valid |
| src_ready | output | 2 | Per-partition result ready |
| src_data | input | 2*W | Per-partition result data, partition i at bits i*W +: W |
| out_valid | output | 1 | Merged output stream valid |
| out_ready | input | 1 | Merged output stream ready |
| out_data | output | W | Merged output stream data |

## Verification
The bench builds the router with W=8 and CW=3. The small count width lets random handoff counts cover the whole range from zero to the maximum, and stalls on an exhausted discard count happen often. Each input token carries a running index, so a lost, repeated or misrouted token shows up in the data compared against the reference model. Each of the three routing schemes gets its own reset and run. The random handoffs also land on the current owner (ignored) and while prefetch slots are full (held across deactivation).

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int NPART = 2;

  typedef enum logic [1:0] {
    ROUTE_BCAST = 2'd0,
    ROUTE_REQ   = 2'd1,
    ROUTE_PREF  = 2'd2
  } route_mode_e;

  function automatic route_mode_e pick_mode(input logic directed, input logic prefetch);
    if (!directed)    return ROUTE_BCAST;
    else if (prefetch) return ROUTE_PREF;
    else               return ROUTE_REQ;
  endfunction
endpackage

// File: rtl/ssr_owner.sv
module ssr_owner (
  input  logic clk,
  input  logic rst_n,
  input  logic hand_vld,
  input  logic hand_to,
  output logic act_vld,
  output logic act_id,
  output logic take
);
  // a handoff naming the present owner changes nothing
  assign take = hand_vld && !(act_vld && (hand_to == act_id));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_vld <= 1'b0;
      act_id  <= 1'b0;
    end else if (take) begin
      act_vld <= 1'b1;
      act_id  <= hand_to;
    end
  end
endmodule

// File: rtl/ssr_discard.sv
module ssr_discard #(
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic                ld_idx,
  input  logic [CW-1:0]       ld_val,
  input  logic                dec_en,
  input  logic                dec_idx,
  output logic [ssr_pkg::NPART-1:0] nz
);
  for (genvar g = 0; g < ssr_pkg::NPART; g++) begin : g_cnt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt <= '0;
      else if (ld_en && ld_idx == 1'(g))
        cnt <= ld_val;
      else if (dec_en && dec_idx == 1'(g) && cnt != '0)
        cnt <= cnt - 1'b1;
    end
    assign nz[g] = (cnt != '0);
  end
endmodule

// File: rtl/ssr_slot.sv
module ssr_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (push) begin
      full <= 1'b1;
      dout <= din;
    end else if (pop) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/ssr_collect.sv
module ssr_collect #(
  parameter int W = 16
) (
  input  logic                          act_vld,
  input  logic                          act_id,
  input  logic [ssr_pkg::NPART-1:0]     src_valid,
  output logic [ssr_pkg::NPART-1:0]     src_ready,
  input  logic [ssr_pkg::NPART*W-1:0]   src_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [W-1:0]                  out_data
);
  always_comb begin
    src_ready = '0;
    out_valid = 1'b0;
    out_data  = src_data[act_id*W +: W];
    if (act_vld) begin
      out_valid         = src_valid[act_id];
      src_ready[act_id] = out_ready;
    end
  end
endmodule

// File: rtl/shared_stream_router.sv
module shared_stream_router #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_directed,
  input  logic           cfg_prefetch,
  input  logic           hand_vld,
  input  logic           hand_to,
  input  logic [CW-1:0]  hand_cnt,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  output logic [1:0]     dlv_valid,
  input  logic [1:0]     dlv_ready,
  output logic [2*W-1:0] dlv_data,
  input  logic [1:0]     src_valid,
  output logic [1:0]     src_ready,
  input  logic [2*W-1:0] src_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data
);
  import ssr_pkg::*;

  route_mode_e mode;
  logic        act_vld, act_id, take, other;
  logic [NPART-1:0] disc_nz, slot_full;
  logic [NPART*W-1:0] slot_dout;
  logic        fire;

  assign mode  = pick_mode(cfg_directed, cfg_prefetch);
  assign other = ~act_id;
  assign fire  = in_valid && in_ready;

  ssr_owner u_owner (
    .clk(clk), .rst_n(rst_n), .hand_vld(hand_vld), .hand_to(hand_to),
    .act_vld(act_vld), .act_id(act_id), .take(take)
  );

  ssr_discard #(.CW(CW)) u_discard (
    .clk(clk), .rst_n(rst_n),
    .ld_en(take), .ld_idx(~hand_to), .ld_val(hand_cnt),
    .dec_en(mode == ROUTE_BCAST && fire && act_vld), .dec_idx(other),
    .nz(disc_nz)
  );

  always_comb begin
    in_ready = 1'b0;
    if (act_vld) begin
      unique case (mode)
        ROUTE_BCAST: in_ready = dlv_ready[act_id] && disc_nz[other];
        ROUTE_REQ:   in_ready = dlv_ready[act_id];
        ROUTE_PREF:  in_ready = !slot_full[act_id] || dlv_ready[act_id];
        default:     in_ready = 1'b0;
      endcase
    end
  end

  for (genvar i = 0; i < NPART; i++) begin : g_part
    logic mine;
    assign mine = act_vld && (act_id == 1'(i));

    ssr_slot #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .push(mode == ROUTE_PREF && mine && fire),
      .pop(mode == ROUTE_PREF && dlv_valid[i] && dlv_ready[i]),
      .din(in_data),
      .full(slot_full[i]),
      .dout(slot_dout[i*W +: W])
    );

    always_comb begin
      unique case (mode)
        ROUTE_BCAST: begin
          dlv_valid[i]       = mine && in_valid && disc_nz[other];
          dlv_data[i*W +: W] = in_data;
        end
        ROUTE_REQ: begin
          dlv_valid[i]       = mine && in_valid;
          dlv_data[i*W +: W] = in_data;
        end
        default: begin
          dlv_valid[i]       = mine && slot_full[i];
          dlv_data[i*W +: W] = slot_dout[i*W +: W];
        end
      endcase
    end
  end

  ssr_collect #(.W(W)) u_collect (
    .act_vld(act_vld), .act_id(act_id),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_directed,
  input logic       cfg_prefetch,
  input logic       hand_vld,
  input logic       hand_to,
  input logic       act_vld,
  input logic       act_id,
  input logic       in_ready,
  input logic [1:0] dlv_valid,
  input logic [1:0] dlv_ready,
  input logic [1:0] src_ready,
  input logic [1:0] disc_nz,
  input logic [1:0] slot_full
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act_vld |-> (!in_ready && dlv_valid == 2'b00 && src_ready == 2'b00));

  assert_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hand_vld && !(act_vld && hand_to == act_id)) |=> (act_vld && act_id == $past(hand_to)));

  assert_self_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hand_vld && act_vld && hand_to == act_id) |=> (act_vld && $stable(act_id)));

  assert_collect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |-> !src_ready[~act_id]);

  assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_directed && act_vld && !disc_nz[~act_id]) |-> !in_ready);

  assert_hold0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_directed && cfg_prefetch && slot_full[0] && !(dlv_valid[0] && dlv_ready[0])) |=> slot_full[0]);

  assert_hold1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_directed && cfg_prefetch && slot_full[1] && !(dlv_valid[1] && dlv_ready[1])) |=> slot_full[1]);

  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dlv_valid));
endmodule

bind shared_stream_router ssr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_directed(cfg_directed), .cfg_prefetch(cfg_prefetch),
  .hand_vld(hand_vld), .hand_to(hand_to), .act_vld(act_vld), .act_id(act_id),
  .in_ready(in_ready), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
  .src_ready(src_ready), .disc_nz(disc_nz), .slot_full(slot_full)
);

// File: tb/test_shared_stream_router.sv
module test_shared_stream_router;
  localparam int W  = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_directed = 1'b0, cfg_prefetch = 1'b0;
  logic hand_vld = 1'b0, hand_to = 1'b0;
  logic [CW-1:0] hand_cnt = '0;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] in_data = '0;
  logic [1:0] dlv_valid, dlv_ready = 2'b00;
  logic [2*W-1:0] dlv_data;
  logic [1:0] src_valid = 2'b00, src_ready;
  logic [2*W-1:0] src_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [W-1:0] out_data;

  always #2ns clk = ~clk;

  shared_stream_router #(.W(W), .CW(CW)) i_shared_stream_router (.*);

  int checks = 0, errors = 0;
  int mode; // 0 bcast, 1 request, 2 prefetch
  bit m_vld; int m_act; int m_disc[2]; bit m_full[2]; int m_sdat[2]; bit m_took;
  int tok;

  task automatic chk(input bit ok, input string req, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, a, e);
    end
  endtask

  task automatic do_reset(input int md);
    rst_n = 1'b0; mode = md;
    cfg_directed = (md != 0); cfg_prefetch = (md == 2);
    hand_vld = 0; in_valid = 0; dlv_ready = 0; src_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_vld = 0; m_act = 0; m_took = 0;
    for (int i = 0; i < 2; i++) begin m_disc[i] = 0; m_full[i] = 0; m_sdat[i] = 0; end
  endtask

  // compare one cycle against the model, then advance the model at the edge
  task automatic step();
    bit e_rdy; bit [1:0] e_dv; int e_dd[2]; bit fire; string rq;
    #1;
    e_rdy = 0;
    if (m_vld) begin
      case (mode)
        0: e_rdy = dlv_ready[m_act] && (m_disc[1-m_act] != 0);
        1: e_rdy = dlv_ready[m_act];
        default: e_rdy = !m_full[m_act] || dlv_ready[m_act];
      endcase
    end
    for (int i = 0; i < 2; i++) begin
      bit mine = m_vld && (m_act == i);
      case (mode)
        0: begin e_dv[i] = mine && in_valid && (m_disc[1-m_act] != 0); e_dd[i] = in_data; end
        1: begin e_dv[i] = mine && in_valid; e_dd[i] = in_data; end
        default: begin e_dv[i] = mine && m_full[i]; e_dd[i] = m_sdat[i]; end
      endcase
    end
    if (!m_vld) rq = "R1";
    else if (mode == 0) rq = (m_disc[1-m_act] == 0) ? "R5" : "R4";
    else if (mode == 1) rq = "R6";
    else rq = "R7";
    chk(in_ready == e_rdy, {rq, " in_ready"}, in_ready, e_rdy);
    for (int i = 0; i < 2; i++) begin
      chk(dlv_valid[i] == e_dv[i], (m_vld && m_act != i) ? "R9 dlv_valid" : {rq, " dlv_valid"},
          dlv_valid[i], e_dv[i]);
      if (e_dv[i] && dlv_valid[i])
        chk(dlv_data[i*W +: W] == W'(e_dd[i]), (mode == 2) ? "R8 dlv_data" : {rq, " dlv_data"},
            dlv_data[i*W +: W], e_dd[i]);
    end
    rq = !m_vld ? "R1" : (m_took ? "R2" : "R3");
    chk(out_valid == (m_vld && src_valid[m_act]), {rq, " out_valid"}, out_valid, m_vld && src_valid[m_act]);
    chk(src_ready == (m_vld ? (2'(out_ready) << m_act) : 2'b00), {rq, " src_ready"},
        src_ready, m_vld ? (out_ready << m_act) : 0);
    if (m_vld && out_valid)
      chk(out_data == src_data[m_act*W +: W], {rq, " out_data"}, out_data, src_data[m_act*W +: W]);
    fire = in_valid && e_rdy;
    @(posedge clk);
    m_took = 0;
    if (mode == 0 && fire && m_vld) m_disc[1-m_act]--;
    if (mode == 2)
      for (int i = 0; i < 2; i++) begin
        if (e_dv[i] && dlv_ready[i]) m_full[i] = 0;
        if (fire && m_vld && m_act == i) begin m_full[i] = 1; m_sdat[i] = in_data; end
      end
    if (hand_vld && !(m_vld && hand_to == m_act)) begin
      m_vld = 1; m_act = hand_to; m_disc[1-hand_to] = hand_cnt; m_took = 1;
    end
    if (fire) tok++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      in_valid  = ($urandom % 4) != 0;
      in_data   = W'(tok);
      dlv_ready = 2'($urandom);
      src_valid = 2'($urandom);
      src_data  = 16'($urandom);
      out_ready = ($urandom % 3) != 0;
      hand_vld  = (c % 6 == 2) && ($urandom % 2 == 1);
      hand_to   = 1'($urandom);
      hand_cnt  = CW'($urandom);
      step();
    end
    hand_vld = 0;
  endtask

  initial begin
    #(4ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(7));
    tok = 0;
    @(negedge clk);
    for (int md = 0; md < 3; md++) begin
      do_reset(md);
      // R1: everything offered while no owner exists
      in_valid = 1; dlv_ready = 2'b11; src_valid = 2'b11; out_ready = 1;
      step();
      // R2: explicit handoff to partition 1, then self-handoff with another count
      hand_vld = 1; hand_to = 1; hand_cnt = 3'd2;
      step();
      hand_vld = 1; hand_to = 1; hand_cnt = 3'd6;
      step();
      hand_vld = 0;
      repeat (4) step();
      run(700);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule